// File: doc/BRIEF.md
# Compaction-Adequacy Prediction Table

This block decides, for each warp that reaches a conditional branch, whether the warp should stop at the compaction barrier and wait for the other warps of its thread block, or go straight past the barrier. It keeps a small fully associative table keyed by the branch address. Each entry stores one bit that says whether the last compaction at that branch actually shrank the number of warps. One table serves every thread block on the core.

A warp that did not diverge never waits and leaves the table alone. A divergent warp whose branch address is not in the table claims an entry, which starts out predicting compaction, so this warp and the warps that follow it all wait. Once every warp of the block has arrived and the compaction unit has formed its new warps, the warp counts before and after compaction are reported. The entry's bit is then rewritten with the outcome, and later divergent warps at that branch take the bypass while the bit is clear. When every entry is in use, the entry that a lookup has touched least recently is reused.

Top module: `adq_predict_table`

## Requirements
- R1: After reset no entry is valid: the first divergent lookup of any address reports `lk_hit`=0 and `lk_compact`=1.
- R2: A lookup with `lk_diverged`=0 gives `lk_compact`=0 (bypass) and `lk_hit`=0 in the same cycle, and allocates nothing: a later divergent lookup of that address still misses.
- R3: A divergent lookup that misses gives `lk_compact`=1 in the same cycle and allocates an entry whose bit is set, so the next divergent lookup of that address gives `lk_hit`=1 and `lk_compact`=1.
- R4: An update (`upd_valid`=1) to an address held in the table writes bit 1 when `warps_after` < `warps_before` and bit 0 otherwise, equal counts included. A later divergent lookup gives `lk_hit`=1 and `lk_compact` equal to that bit.
- R5: An update to an address not held in the table changes nothing: other entries keep their bits, and the address still misses on its next lookup.
- R6: When a divergent lookup and an update name the same held address in the same cycle, the update wins and `lk_compact` already shows the new outcome in that cycle.
- R7: Empty entries are filled before any valid entry is replaced. With all entries valid, a missing divergent lookup replaces the entry that lookups touched least recently. Hits and allocations count as touches. Updates do not.
- R8: While `lk_valid`=0, both `lk_hit` and `lk_compact` are 0.
- R9: A lookup hit leaves the entry's bit unchanged, so repeated hits keep giving the same decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | A warp is at a branch this cycle |
| lk_pc | input | PC_W | Branch instruction address of the lookup |
| lk_diverged | input | 1 | The warp's threads split at this branch |
| upd_valid | input | 1 | All warps of a block arrived, compaction done at `upd_pc` |
| upd_pc | input | PC_W | Branch address of the evaluated compaction |
| warps_before | input | $clog2(MAX_WARPS+1) | Warp count before compaction |
| warps_after | input | $clog2(MAX_WARPS+1) | Warp count after compaction |
| lk_compact | output | 1 | 1 = wait at barrier, 0 = bypass |
| lk_hit | output | 1 | The divergent lookup matched a valid entry |

## Verification
Checks that run on every cycle cover the per-cycle decision rules: outputs stay quiet with no lookup, non-divergent warps bypass, a divergent miss compacts, an allocation is followed by a hit on an immediate repeat of the address, and a forwarded update decides the lookup of the same cycle. Only the bench scenarios can show what depends on history over many cycles. These are the adequacy bit written by updates (including the equal-count case), updates to absent addresses being dropped, hits leaving the bit alone, and the least-recently-used choice once all entries are full.

// File: rtl/adq_pkg.sv
package adq_pkg;

  typedef enum logic {
    DEC_BYPASS  = 1'b0,
    DEC_COMPACT = 1'b1
  } adq_dec_e;

  // Compaction paid off only if it produced strictly fewer warps.
  function automatic logic is_adequate(input int unsigned before_cnt,
                                       input int unsigned after_cnt);
    return after_cnt < before_cnt;
  endfunction

endpackage

// File: rtl/adq_tag_cam.sv
module adq_tag_cam #(
  parameter int ENTRIES = 32,
  parameter int PC_W    = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]      valid_vec,
  input  logic [ENTRIES*PC_W-1:0] tags_flat,
  input  logic [PC_W-1:0]         key,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);

  logic [ENTRIES-1:0] match_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_vec[g] && (tags_flat[g*PC_W +: PC_W] == key);
  end

  assign hit = |match_vec;

  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/adq_age_lru.sv
module adq_age_lru #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);

  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  // Ages always form a permutation of 0..ENTRIES-1; 0 is the newest.
  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] touched_age;

  function automatic logic [IDX_W-1:0] next_age(input logic [IDX_W-1:0] cur,
                                                input logic [IDX_W-1:0] ref_age,
                                                input logic             is_me);
    if (is_me)              return '0;
    else if (cur < ref_age) return cur + 1'b1;
    else                    return cur;
  endfunction

  assign touched_age = age_q[touch_idx];

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (!rst_n)     age_q[i] <= IDX_W'(i);
      else if (touch) age_q[i] <= next_age(age_q[i], touched_age, touch_idx == IDX_W'(i));
    end
  end

  // Never-touched entries stay older than any touched one, so they go first.
  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (age_q[i] == OLDEST) victim_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/adq_predict_table.sv
module adq_predict_table
  import adq_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int ENTRIES   = 32,
  parameter int MAX_WARPS = 32,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int CNT_W    = $clog2(MAX_WARPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic             lk_diverged,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic [CNT_W-1:0] warps_before,
  input  logic [CNT_W-1:0] warps_after,
  output logic             lk_compact,
  output logic             lk_hit
);

  logic [ENTRIES-1:0]      valid_q;
  logic [ENTRIES*PC_W-1:0] tags_q;
  logic [ENTRIES-1:0]      hist_q;

  // Named internal events, also watched by the checker.
  logic             lk_match, upd_match;
  logic [IDX_W-1:0] lk_idx, upd_idx, victim_idx, touch_idx;
  logic             adequate_w;
  logic             lookup_div;
  logic             alloc_evt;
  logic             upd_evt;
  logic             fwd_evt;
  logic             stored_bit;
  adq_dec_e         decision;

  adq_tag_cam #(.ENTRIES(ENTRIES), .PC_W(PC_W), .IDX_W(IDX_W)) u_lk_cam (
    .valid_vec (valid_q),
    .tags_flat (tags_q),
    .key       (lk_pc),
    .hit       (lk_match),
    .idx       (lk_idx)
  );

  adq_tag_cam #(.ENTRIES(ENTRIES), .PC_W(PC_W), .IDX_W(IDX_W)) u_upd_cam (
    .valid_vec (valid_q),
    .tags_flat (tags_q),
    .key       (upd_pc),
    .hit       (upd_match),
    .idx       (upd_idx)
  );

  adq_age_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch      (lookup_div),
    .touch_idx  (touch_idx),
    .victim_idx (victim_idx)
  );

  assign adequate_w = is_adequate(32'(warps_before), 32'(warps_after));
  assign lookup_div = lk_valid && lk_diverged;
  assign alloc_evt  = lookup_div && !lk_match;
  assign upd_evt    = upd_valid && upd_match;
  assign fwd_evt    = lookup_div && lk_match && upd_evt && (upd_idx == lk_idx);
  assign touch_idx  = lk_match ? lk_idx : victim_idx;
  assign stored_bit = fwd_evt ? adequate_w : hist_q[lk_idx];

  always_comb begin
    decision = DEC_BYPASS;
    if (lookup_div) begin
      if (!lk_match || stored_bit) decision = DEC_COMPACT;
    end
  end

  assign lk_compact = (decision == DEC_COMPACT);
  assign lk_hit     = lookup_div && lk_match;

  // Allocation claims the whole entry and beats an update to the evicted one.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      tags_q  <= '0;
      hist_q  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (alloc_evt && (victim_idx == IDX_W'(i))) begin
          valid_q[i]              <= 1'b1;
          tags_q[i*PC_W +: PC_W]  <= lk_pc;
          hist_q[i]               <= 1'b1;
        end else if (upd_evt && (upd_idx == IDX_W'(i))) begin
          hist_q[i]               <= adequate_w;
        end
      end
    end
  end

endmodule

// File: rtl/adq_predict_table_chk.sv
module adq_predict_table_chk #(
  parameter int PC_W  = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [PC_W-1:0]  lk_pc,
  input logic             lk_diverged,
  input logic [CNT_W-1:0] warps_before,
  input logic [CNT_W-1:0] warps_after,
  input logic             lk_hit,
  input logic             lk_compact,
  input logic             alloc_evt,
  input logic             fwd_evt
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_compact)); // R8

  AST_NODIV_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_diverged) |-> (!lk_compact && !lk_hit)); // R2

  AST_MISS_COMPACTS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_diverged && !lk_hit) |-> lk_compact); // R3

  AST_ALLOC_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_evt |=> (!(lk_valid && lk_diverged && lk_pc == $past(lk_pc)) || (lk_hit && lk_compact))); // R3

  AST_FWD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_evt |-> (lk_hit && (lk_compact == (warps_after < warps_before)))); // R6

endmodule

bind adq_predict_table adq_predict_table_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_valid     (lk_valid),
  .lk_pc        (lk_pc),
  .lk_diverged  (lk_diverged),
  .warps_before (warps_before),
  .warps_after  (warps_after),
  .lk_hit       (lk_hit),
  .lk_compact   (lk_compact),
  .alloc_evt    (alloc_evt),
  .fwd_evt      (fwd_evt)
);

// File: tb/test_adq_predict_table.sv
`timescale 1ns/1ps
module test_adq_predict_table;

  localparam int PC_W  = 32;
  localparam int CNT_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             lk_valid = 1'b0;
  logic [PC_W-1:0]  lk_pc = '0;
  logic             lk_diverged = 1'b0;
  logic             upd_valid = 1'b0;
  logic [PC_W-1:0]  upd_pc = '0;
  logic [CNT_W-1:0] warps_before = '0;
  logic [CNT_W-1:0] warps_after = '0;
  logic             lk_compact, lk_hit;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [PC_W-1:0] PC_A = 32'h0000_1000;
  localparam logic [PC_W-1:0] PC_B = 32'h0000_2040;
  localparam logic [PC_W-1:0] PC_C = 32'h0000_3080;

  always #5 clk = ~clk;

  adq_predict_table i_adq_predict_table (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_diverged(lk_diverged),
    .upd_valid(upd_valid), .upd_pc(upd_pc),
    .warps_before(warps_before), .warps_after(warps_after),
    .lk_compact(lk_compact), .lk_hit(lk_hit)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input logic div,
                      input logic exp_hit, input logic exp_cmp, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc; lk_diverged = div;
    #1;
    chk(lk_hit, exp_hit, req, $sformatf("hit pc=%h", pc));
    chk(lk_compact, exp_cmp, req, $sformatf("compact pc=%h", pc));
    @(posedge clk); #1;
    lk_valid = 1'b0; lk_diverged = 1'b0;
  endtask

  task automatic upd(input logic [PC_W-1:0] pc, input int before_n, input int after_n);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc;
    warps_before = CNT_W'(before_n); warps_after = CNT_W'(after_n);
    @(posedge clk); #1;
    upd_valid = 1'b0;
  endtask

  task automatic fwd(input logic [PC_W-1:0] pc, input int before_n, input int after_n,
                     input logic exp_cmp);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc;
    warps_before = CNT_W'(before_n); warps_after = CNT_W'(after_n);
    lk_valid = 1'b1; lk_pc = pc; lk_diverged = 1'b1;
    #1;
    chk(lk_hit, 1'b1, "R6", "forwarded hit");
    chk(lk_compact, exp_cmp, "R6", "forwarded compact");
    @(posedge clk); #1;
    upd_valid = 1'b0; lk_valid = 1'b0; lk_diverged = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    lk_pc = PC_A; lk_diverged = 1'b1; lk_valid = 1'b0;
    #1;
    chk(lk_hit, 1'b0, "R8", "idle hit");
    chk(lk_compact, 1'b0, "R8", "idle compact");
    lk_diverged = 1'b0;
    look(PC_A, 1'b1, 1'b0, 1'b1, "R1");
  endtask

  task automatic t_alloc;
    look(PC_A, 1'b1, 1'b1, 1'b1, "R3");
  endtask

  task automatic t_nodiv;
    look(PC_B, 1'b0, 1'b0, 1'b0, "R2");
    look(PC_B, 1'b1, 1'b0, 1'b1, "R2");
  endtask

  task automatic t_adequacy;
    upd(PC_A, 4, 3);
    look(PC_A, 1'b1, 1'b1, 1'b1, "R4");
    upd(PC_A, 4, 4);
    look(PC_A, 1'b1, 1'b1, 1'b0, "R4");
    upd(PC_B, 2, 5);
    look(PC_B, 1'b1, 1'b1, 1'b0, "R4");
    look(PC_B, 1'b1, 1'b1, 1'b0, "R9");
    upd(PC_A, 5, 1);
    look(PC_A, 1'b1, 1'b1, 1'b1, "R4");
  endtask

  task automatic t_absent;
    upd(PC_C, 2, 1);
    look(PC_B, 1'b1, 1'b1, 1'b0, "R5");
    look(PC_A, 1'b1, 1'b1, 1'b1, "R5");
    look(PC_C, 1'b1, 1'b0, 1'b1, "R5");
  endtask

  task automatic t_forward;
    fwd(PC_B, 3, 1, 1'b1);
    look(PC_B, 1'b1, 1'b1, 1'b1, "R6");
    fwd(PC_A, 3, 3, 1'b0);
    look(PC_A, 1'b1, 1'b1, 1'b0, "R6");
  endtask

  // Touch order before this: C oldest, then B, then A; 29 fills make 32 entries.
  task automatic t_lru;
    for (int k = 0; k < 29; k++) begin
      look(32'h0001_0000 + 32'(k * 4), 1'b1, 1'b0, 1'b1, "R7");
    end
    look(PC_A, 1'b1, 1'b1, 1'b0, "R7");
    look(32'h0000_9000, 1'b1, 1'b0, 1'b1, "R7");
    look(PC_B, 1'b1, 1'b1, 1'b1, "R7");
    look(PC_C, 1'b1, 1'b0, 1'b1, "R7");
    look(32'h0001_0004, 1'b1, 1'b1, 1'b1, "R7");
    look(32'h0001_0000, 1'b1, 1'b0, 1'b1, "R7");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_alloc();
    t_nodiv();
    t_adequacy();
    t_absent();
    t_forward();
    t_lru();
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule